// File: doc/BRIEF.md
# Systolic Linear-Array Sorter

A chain of identical compare-and-hold cells that sorts up to `N_CELLS` unsigned keys into ascending order. Keys are offered one per clock at the left end of the chain and ripple rightward through registered links. Each cell exchanges data only with the cells on either side of it, so no wire spans the chain and no operand is broadcast. Every cell holds one slot that starts out empty. An empty slot ranks above any real key. An arriving key is compared with the held one. The larger of the two moves on to the right and the smaller stays.

A load ends in one of two ways: the producer marks the final key with `key_last_i`, or the chain has taken `N_CELLS` keys. A settle window then lets keys still moving through the links come to rest. After that the cells shift their contents left, one slot per clock, and the smallest key leaves first on `out_key_o` with `out_valid_o`. A one-cycle `done_o` pulse follows the last key out, and the block returns to loading.

Top module: `systolic_sorter`

## Requirements
- R1: The keys leaving on `out_key_o` during one unload are in non-decreasing order, with duplicate keys each delivered once.
- R2: A load of 1 to `N_CELLS` keys is accepted. It ends on an accepted key with `key_last_i` high, or on the `N_CELLS`-th accepted key, whichever comes first.
- R3: When a cell holds a key and a key arrives, the larger of the two moves to the right neighbour and the smaller stays. On a tie the arriving key stays and the held copy moves on. A key forwarded by a cell is never smaller than the key that cell then holds.
- R4: An empty slot entering a cell leaves that cell's held contents unchanged, and a held key is never replaced by an empty slot while loading.
- R5: `key_ready_o` is high only in the load phase. A key offered while it is low is dropped and never shows up on the output.
- R6: The first `out_valid_o` comes exactly `N_CELLS`+1 cycles after the clock edge that accepts the final key. `out_valid_o` then stays high for one consecutive cycle per loaded key.
- R7: `done_o` is high for exactly one cycle, the cycle right after the last `out_valid_o`. `key_ready_o` is high again in the following cycle.
- R8: After reset, `out_valid_o` and `done_o` are low and `key_ready_o` is high.
- R9: No key ever passes beyond the rightmost cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_valid_i | input | 1 | A key is offered on key_i |
| key_i | input | KEY_W | Unsigned key |
| key_last_i | input | 1 | The offered key is the final one of this load |
| key_ready_o | output | 1 | The block is loading and accepts the offered key |
| out_valid_o | output | 1 | out_key_o carries a sorted key |
| out_key_o | output | KEY_W | Sorted key, smallest first |
| done_o | output | 1 | One-cycle pulse after the last sorted key |

## Verification
The assertions assume that no load holds more than `N_CELLS` keys. They also assume that keys are offered only while `key_ready_o` is high, with the single exception of deliberate drop tests. The stimulus keeps load lengths between 1 and `N_CELLS` and inserts random idle gaps between keys. It also injects one stray key during each unload to check that the key is dropped. Directed runs cover a full ascending load, a full descending load, a load of all-equal keys, a single-key load and a full load with duplicates.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
  parameter int unsigned KEY_W = 8;

  typedef struct packed {
    logic             valid;
    logic [KEY_W-1:0] key;
  } slot_t;

  localparam slot_t SLOT_EMPTY = '{valid: 1'b0, key: '0};
endpackage

// File: rtl/sort_cell.sv
module sort_cell
  import sorter_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  drain_i,
  input  slot_t left_i,
  input  slot_t right_i,
  output slot_t fwd_o,
  output slot_t held_o
);
  slot_t held_q, fwd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= SLOT_EMPTY;
      fwd_q  <= SLOT_EMPTY;
    end else if (drain_i) begin
      held_q <= right_i;
      fwd_q  <= SLOT_EMPTY;
    end else if (left_i.valid) begin
      if (held_q.valid && (left_i.key > held_q.key)) begin
        fwd_q <= left_i;
      end else begin
        // empty held slot ranks highest; ties keep the newcomer
        fwd_q  <= held_q;
        held_q <= left_i;
      end
    end else begin
      fwd_q <= SLOT_EMPTY;
    end
  end

  assign fwd_o  = fwd_q;
  assign held_o = held_q;

  AST_FWD_NOT_SMALLER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_q.valid && held_q.valid) |-> (fwd_q.key >= held_q.key)); // R3
  AST_EMPTY_NOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drain_i && !left_i.valid) |=> $stable(held_q)); // R4
  AST_KEY_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drain_i && held_q.valid) |=> held_q.valid); // R4
endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl #(
  parameter int unsigned N_CELLS = 8,
  localparam int unsigned CNT_W = $clog2(N_CELLS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_valid_i,
  input  logic key_last_i,
  input  logic head_valid_i,
  output logic ready_o,
  output logic accept_o,
  output logic drain_o,
  output logic done_o
);
  typedef enum logic [1:0] {ST_LOAD, ST_SETTLE, ST_DRAIN} state_e;

  state_e           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             load_end;

  assign ready_o  = (state_q == ST_LOAD);
  assign accept_o = ready_o && key_valid_i;
  assign drain_o  = (state_q == ST_DRAIN);
  assign load_end = accept_o && (key_last_i || (cnt_q == CNT_W'(N_CELLS - 1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_LOAD: begin
          if (load_end) begin
            state_q <= ST_SETTLE;
            cnt_q   <= CNT_W'(N_CELLS - 1);
          end else if (accept_o) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (cnt_q == '0) state_q <= ST_DRAIN;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_DRAIN: begin
          if (!head_valid_i) begin
            state_q <= ST_LOAD;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_LOAD;
      endcase
    end
  end

  assign done_o = done_q;

  AST_NO_ACCEPT_OFF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_LOAD) |-> !accept_o); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R7
  AST_DONE_TO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ready_o); // R7
endmodule

// File: rtl/systolic_sorter.sv
module systolic_sorter
  import sorter_pkg::*;
#(
  parameter int unsigned N_CELLS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_valid_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             key_last_i,
  output logic             key_ready_o,
  output logic             out_valid_o,
  output logic [KEY_W-1:0] out_key_o,
  output logic             done_o
);
  slot_t link [N_CELLS+1];
  slot_t held [N_CELLS+1];
  logic  accept, drain;
  logic             out_valid_q;
  logic [KEY_W-1:0] out_key_q;

  sort_ctrl #(.N_CELLS(N_CELLS)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .key_valid_i  (key_valid_i),
    .key_last_i   (key_last_i),
    .head_valid_i (held[0].valid),
    .ready_o      (key_ready_o),
    .accept_o     (accept),
    .drain_o      (drain),
    .done_o       (done_o)
  );

  assign link[0]       = accept ? slot_t'{valid: 1'b1, key: key_i} : SLOT_EMPTY;
  assign held[N_CELLS] = SLOT_EMPTY;

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    sort_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .drain_i (drain),
      .left_i  (link[g]),
      .right_i (held[g+1]),
      .fwd_o   (link[g+1]),
      .held_o  (held[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_key_q   <= '0;
    end else begin
      out_valid_q <= drain && held[0].valid;
      if (drain && held[0].valid) out_key_q <= held[0].key;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_key_o   = out_key_q;

  AST_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(out_valid_o)) |-> (out_key_o >= $past(out_key_o))); // R1
  AST_NO_SPILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link[N_CELLS].valid); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!out_valid_o && $past(out_valid_o))); // R7
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_ready_o |-> !out_valid_o); // R5
endmodule

// File: tb/systolic_sorter_bench.sv
module systolic_sorter_bench;
  localparam int N = 8;
  localparam int KW = sorter_pkg::KEY_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic key_valid_i = 1'b0;
  logic [KW-1:0] key_i = '0;
  logic key_last_i = 1'b0;
  logic key_ready_o, out_valid_o, done_o;
  logic [KW-1:0] out_key_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int vec [N];
  int expv [N];

  systolic_sorter #(.N_CELLS(N)) u_systolic_sorter (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void sort_ref(input int n);
    for (int i = 0; i < n; i++) expv[i] = vec[i];
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n - 1 - i; j++)
        if (expv[j] > expv[j+1]) begin
          int t = expv[j]; expv[j] = expv[j+1]; expv[j+1] = t;
        end
  endfunction

  // n keys from vec; last marked only when n < N (R2 auto-end at N)
  task automatic run_case(input int n, input bit gaps);
    int lat;
    sort_ref(n);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        key_valid_i = 1'b0;
        @(negedge clk_i);
      end
      chk(key_ready_o, "R5 ready in load", key_ready_o, 1);
      key_valid_i = 1'b1;
      key_i = KW'(vec[i]);
      key_last_i = (i == n - 1) && (n < N);
      @(negedge clk_i);
    end
    key_valid_i = 1'b0;
    key_last_i = 1'b0;
    chk(!key_ready_o, "R2 load ended", key_ready_o, 0);
    lat = 0;
    while (!out_valid_o && lat < 4 * N) begin
      if (lat == 1) begin
        key_valid_i = 1'b1; // stray key while not ready, must be dropped (R5)
        key_i = '0;
      end else begin
        key_valid_i = 1'b0;
      end
      @(negedge clk_i);
      lat++;
    end
    key_valid_i = 1'b0;
    chk(lat == N + 1, "R6 latency", lat, N + 1);
    for (int k = 0; k < n; k++) begin
      chk(out_valid_o, "R6 valid run", out_valid_o, 1);
      chk(out_key_o == KW'(expv[k]), "R1 order", out_key_o, expv[k]);
      chk(!done_o, "R7 no early done", done_o, 0);
      @(negedge clk_i);
    end
    chk(!out_valid_o, "R6 run length", out_valid_o, 0);
    chk(done_o, "R7 done pulse", done_o, 1);
    @(negedge clk_i);
    chk(!done_o, "R7 single pulse", done_o, 0);
    chk(key_ready_o, "R7 ready again", key_ready_o, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(!out_valid_o, "R8 out_valid reset", out_valid_o, 0);
    chk(!done_o, "R8 done reset", done_o, 0);
    chk(key_ready_o, "R8 ready reset", key_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < N; i++) vec[i] = i * 3 + 1;
    run_case(N, 1'b0); // R2 full ascending
    for (int i = 0; i < N; i++) vec[i] = 200 - i * 7;
    run_case(N, 1'b0); // R3 full descending
    for (int i = 0; i < N; i++) vec[i] = 42;
    run_case(N, 1'b0); // R3 ties
    vec[0] = 255;
    run_case(1, 1'b0); // R2 single key
    for (int i = 0; i < N; i++) vec[i] = (i % 3) * 50;
    run_case(N, 1'b1); // R1 duplicates
    for (int i = 0; i < 5; i++) vec[i] = 9 - i;
    run_case(5, 1'b1); // R4 partial load
    for (int r = 0; r < 40; r++) begin
      int n = 1 + ($urandom % N);
      for (int i = 0; i < n; i++) vec[i] = $urandom % 256;
      run_case(n, 1'b1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule